// File: doc/BRIEF.md
# Sub-Second Timekeeping Core with Match and Interval Alarms

This block keeps time from a slow tick strobe. A sub-second counter advances by one on every accepted tick. When it wraps from all ones to zero it carries into a wider seconds counter. Ticks are accepted only while the run input is high. Both counts are driven straight onto output ports.

Two alarms watch the count. The match alarm compares a configured value against the low bits of the seconds counter. It raises its pending flag on the tick that moves the seconds counter onto a matching value. The interval alarm is a tick down-counter. A load strobe arms it with a reload value. It raises its pending flag every reload-value ticks and re-arms itself from the reload value on the same edge.

Each pending flag stays set until a one-cycle strobe on its own clear input. Each flag can serve as a wake-up source. The interrupt output combines the flags with their per-alarm enables. The tick strobe is expected to be synchronous to the block clock and one clock cycle wide.

Top module: `subsec_timer_core`

## Requirements
- R1: After reset the sub-second count, the seconds count, both pending flags and the interrupt output are all zero.
- R2: The sub-second count (8 bits by default) increases by one on each clock edge where run and tick are both high, and holds otherwise.
- R3: On the edge where an accepted tick meets a sub-second count of 0xFF, the sub-second count becomes 0x00 and the seconds count (32 bits by default) increases by one. At all other times the seconds count holds.
- R4: While run is low, ticks have no effect: both counts hold, and the interval down-counter does not advance.
- R5: The match pending flag is set on the edge where the seconds count steps to a value whose bits 19:0 equal the 20-bit match value.
- R6: The match flag is not set again while the seconds count stays on a matching value. After it is cleared in the middle of a matching second, it stays clear for the rest of that second.
- R7: After a load strobe with reload value N (N ≥ 1), the interval pending flag is set on the Nth following accepted tick. The down-counter reloads N on that same edge, so the flag is set again every N accepted ticks.
- R8: A reload value of 0 leaves the interval alarm idle, and it sets no flag. This holds whether the 0 arrives through a load strobe or through a reload that takes place at expiry.
- R9: The interrupt output is high exactly when at least one pending flag is set together with its own enable input. A set flag whose enable is low does not drive the interrupt.
- R10: A one-cycle clear strobe clears only its own alarm's pending flag and leaves the other flag unchanged. If a set and a clear for the same flag fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counting enable; ticks are ignored while low |
| tick | input | 1 | One-cycle timer tick strobe |
| match_val | input | 20 | Match alarm value, compared with seconds bits 19:0 |
| reload_val | input | 32 | Interval alarm reload value in ticks |
| reload_load | input | 1 | Strobe that loads reload_val into the interval down-counter |
| match_ie | input | 1 | Interrupt enable for the match alarm |
| intv_ie | input | 1 | Interrupt enable for the interval alarm |
| match_clr | input | 1 | Clear strobe for the match pending flag |
| intv_clr | input | 1 | Clear strobe for the interval pending flag |
| sub_cnt | output | 8 | Sub-second count |
| sec_cnt | output | 32 | Seconds count |
| match_pend | output | 1 | Match alarm pending flag |
| intv_pend | output | 1 | Interval alarm pending flag |
| irq | output | 1 | Combined interrupt |

## Verification
The two counts appear directly on the ports. A wrong increment or a wrong carry therefore shows up on the edge after the faulty tick and stays visible from then on.

A down-counter that is off by one cannot be seen directly. The interval flag then rises one tick early or late, so the bench samples the flag on the tick before the expected expiry and on the expiry tick itself. A match detector that is edge-blind shows up as a flag that comes back after a clear within the matching second. A wrong gating term shows up on irq in the same cycle that a flag or an enable changes.

// File: rtl/sst_pkg.sv
package sst_pkg;

   typedef enum int unsigned {
      ALM_MATCH = 0,
      ALM_INTV  = 1
   } alarm_idx_e;

   localparam int unsigned NUM_ALARMS = 2;

   function automatic logic any_enabled(input logic [NUM_ALARMS-1:0] pend,
                                        input logic [NUM_ALARMS-1:0] ena);
      return |(pend & ena);
   endfunction

endpackage

// File: rtl/sst_count_chain.sv
module sst_count_chain #(
   parameter int SUB_W = 8,
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic             adv,
   output logic             sec_step,
   output logic [SUB_W-1:0] sub_q,
   output logic [SEC_W-1:0] sec_q
);

   localparam logic [SUB_W-1:0] SUB_TOP = {SUB_W{1'b1}};

   if (SUB_W < 1 || SEC_W < 1) begin : g_bad_width
      $error("sst_count_chain: widths must be positive");
   end

   assign adv      = run & tick;
   assign sec_step = adv & (sub_q == SUB_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         sec_q <= '0;
      end else begin
         if (adv)      sub_q <= sub_q + 1'b1;
         if (sec_step) sec_q <= sec_q + 1'b1;
      end
   end

   AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (sub_q == SUB_W'($past(sub_q) + 1'b1))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick) |=> ($stable(sub_q) && $stable(sec_q))); // R4

   AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && sub_q == SUB_TOP) |=> (sec_q == SEC_W'($past(sec_q) + 1'b1) && sub_q == '0)); // R3

endmodule

// File: rtl/sst_match_alarm.sv
module sst_match_alarm #(
   parameter int MATCH_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_step,
   input  logic [MATCH_W-1:0] sec_low,
   input  logic [MATCH_W-1:0] match_val,
   input  logic               clr,
   output logic               pend
);

   logic [MATCH_W-1:0] next_low;
   logic               hit;

   if (MATCH_W < 1) begin : g_bad_width
      $error("sst_match_alarm: MATCH_W must be positive");
   end

   // Compare the value the seconds counter is about to take, so the flag
   // rises once on entry into a matching second.
   assign next_low = sec_low + 1'b1;
   assign hit      = sec_step & (next_low == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (hit) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   AST_MATCH_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(sec_step)); // R5

   AST_MATCH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_step && next_low == match_val && clr) |=> pend); // R10

endmodule

// File: rtl/sst_interval_alarm.sv
module sst_interval_alarm #(
   parameter int RELOAD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic                load,
   input  logic [RELOAD_W-1:0] reload_val,
   input  logic                clr,
   output logic                pend
);

   localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

   logic [RELOAD_W-1:0] dcnt;
   logic                fire;

   if (RELOAD_W < 1) begin : g_bad_width
      $error("sst_interval_alarm: RELOAD_W must be positive");
   end

   // A zero count is the idle state: nothing counts and nothing fires.
   assign fire = adv & ~load & (dcnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt <= '0;
      end else if (load) begin
         dcnt <= reload_val;
      end else if (adv && dcnt != '0) begin
         if (dcnt == ONE) dcnt <= reload_val;
         else             dcnt <= dcnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend <= 1'b0;
      else if (fire) pend <= 1'b1;
      else if (clr)  pend <= 1'b0;
   end

   AST_INTV_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(adv && dcnt == ONE)); // R7

   AST_INTV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dcnt == '0 && !load) |=> (dcnt == '0)); // R8

   AST_INTV_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(dcnt)); // R4

endmodule

// File: rtl/subsec_timer_core.sv
module subsec_timer_core #(
   parameter int SUB_W    = 8,
   parameter int SEC_W    = 32,
   parameter int MATCH_W  = 20,
   parameter int RELOAD_W = 32,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                tick,
   input  logic [MATCH_W-1:0]  match_val,
   input  logic [RELOAD_W-1:0] reload_val,
   input  logic                reload_load,
   input  logic                match_ie,
   input  logic                intv_ie,
   input  logic                match_clr,
   input  logic                intv_clr,
   output logic [SUB_W-1:0]    sub_cnt,
   output logic [SEC_W-1:0]    sec_cnt,
   output logic                match_pend,
   output logic                intv_pend,
   output logic                irq
);
   import sst_pkg::*;

   if (MATCH_W > SEC_W) begin : g_bad_match
      $error("subsec_timer_core: MATCH_W cannot exceed SEC_W");
   end

   logic                  adv;
   logic                  sec_step;
   logic [NUM_ALARMS-1:0] pend_v;
   logic [NUM_ALARMS-1:0] ie_v;
   logic                  irq_c;

   sst_count_chain #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .adv      (adv),
      .sec_step (sec_step),
      .sub_q    (sub_cnt),
      .sec_q    (sec_cnt)
   );

   sst_match_alarm #(.MATCH_W(MATCH_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_step  (sec_step),
      .sec_low   (sec_cnt[MATCH_W-1:0]),
      .match_val (match_val),
      .clr       (match_clr),
      .pend      (match_pend)
   );

   sst_interval_alarm #(.RELOAD_W(RELOAD_W)) u_intv (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .load       (reload_load),
      .reload_val (reload_val),
      .clr        (intv_clr),
      .pend       (intv_pend)
   );

   assign pend_v[ALM_MATCH] = match_pend;
   assign pend_v[ALM_INTV]  = intv_pend;
   assign ie_v[ALM_MATCH]   = match_ie;
   assign ie_v[ALM_INTV]    = intv_ie;
   assign irq_c             = any_enabled(pend_v, ie_v);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;

      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ((!match_pend || !match_ie) && (!intv_pend || !intv_ie)) |-> !irq); // R9

      AST_IRQ_LOUD: assert property (@(posedge clk) disable iff (!rst_n)
         ((match_pend && match_ie) || (intv_pend && intv_ie)) |-> irq); // R9
   end

   AST_CLR_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (match_clr && !intv_clr && intv_pend) |=> intv_pend); // R10

endmodule

// File: tb/sim_subsec_timer_core.sv
module sim_subsec_timer_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        tick = 1'b0;
   logic [19:0] match_val = '0;
   logic [31:0] reload_val = '0;
   logic        reload_load = 1'b0;
   logic        match_ie = 1'b0;
   logic        intv_ie = 1'b0;
   logic        match_clr = 1'b0;
   logic        intv_clr = 1'b0;
   logic [7:0]  sub_cnt;
   logic [31:0] sec_cnt;
   logic        match_pend;
   logic        intv_pend;
   logic        irq;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   subsec_timer_core u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .match_val(match_val), .reload_val(reload_val), .reload_load(reload_load),
      .match_ie(match_ie), .intv_ie(intv_ie), .match_clr(match_clr), .intv_clr(intv_clr),
      .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .match_pend(match_pend),
      .intv_pend(intv_pend), .irq(irq)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic pulse_match_clr();
      @(negedge clk); match_clr = 1'b1;
      @(negedge clk); match_clr = 1'b0;
   endtask

   task automatic pulse_intv_clr();
      @(negedge clk); intv_clr = 1'b1;
      @(negedge clk); intv_clr = 1'b0;
   endtask

   task automatic pulse_load(logic [31:0] v);
      @(negedge clk); reload_val = v; reload_load = 1'b1;
      @(negedge clk); reload_load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "sub after reset", 32'(sub_cnt), 0);
      chk("R1", "sec after reset", sec_cnt, 0);
      chk("R1", "match flag after reset", 32'(match_pend), 0);
      chk("R1", "interval flag after reset", 32'(intv_pend), 0);
      chk("R1", "irq after reset", 32'(irq), 0);
   endtask

   task automatic t_count();
      do_ticks(10);
      chk("R2", "sub after 10 ticks", 32'(sub_cnt), 10);
      chk("R2", "sec after 10 ticks", sec_cnt, 0);
      repeat (3) @(negedge clk);
      chk("R2", "sub holds with no tick", 32'(sub_cnt), 10);
   endtask

   task automatic t_run_gate();
      @(negedge clk); run = 1'b0;
      do_ticks(20);
      chk("R4", "sub holds while run low", 32'(sub_cnt), 10);
      chk("R4", "sec holds while run low", sec_cnt, 0);
      @(negedge clk); run = 1'b1;
   endtask

   task automatic t_carry();
      do_ticks(245);
      chk("R3", "sub at top", 32'(sub_cnt), 255);
      chk("R3", "sec before carry", sec_cnt, 0);
      do_ticks(1);
      chk("R3", "sub wraps", 32'(sub_cnt), 0);
      chk("R3", "sec carries", sec_cnt, 1);
   endtask

   task automatic t_match();
      do_ticks(255);
      do_ticks(256);
      chk("R5", "sec before match", sec_cnt, 2);
      chk("R5", "no match flag one tick early", 32'(match_pend), 0);
      do_ticks(1);
      chk("R5", "sec at match", sec_cnt, 3);
      chk("R5", "match flag set", 32'(match_pend), 1);
      chk("R9", "irq low with enable off", 32'(irq), 0);
      @(negedge clk); match_ie = 1'b1;
      @(negedge clk);
      chk("R9", "irq high with enable on", 32'(irq), 1);
      pulse_match_clr();
      chk("R10", "match flag cleared", 32'(match_pend), 0);
      chk("R9", "irq low after clear", 32'(irq), 0);
      do_ticks(50);
      chk("R6", "still in matching second", sec_cnt, 3);
      chk("R6", "match flag not set again", 32'(match_pend), 0);
      chk("R8", "interval idle without load", 32'(intv_pend), 0);
   endtask

   task automatic t_interval();
      pulse_load(5);
      do_ticks(4);
      chk("R7", "no interval flag after 4 of 5", 32'(intv_pend), 0);
      do_ticks(1);
      chk("R7", "interval flag at 5", 32'(intv_pend), 1);
      pulse_intv_clr();
      chk("R10", "interval flag cleared", 32'(intv_pend), 0);
      do_ticks(4);
      chk("R7", "no flag 4 into second period", 32'(intv_pend), 0);
      do_ticks(1);
      chk("R7", "flag again after reload", 32'(intv_pend), 1);
      pulse_intv_clr();
      @(negedge clk); run = 1'b0;
      do_ticks(10);
      chk("R4", "interval does not count while run low", 32'(intv_pend), 0);
      @(negedge clk); run = 1'b1;
      do_ticks(4);
      chk("R4", "interval resumes without early fire", 32'(intv_pend), 0);
      do_ticks(1);
      chk("R7", "interval fires after resume", 32'(intv_pend), 1);
   endtask

   task automatic t_reload_zero();
      pulse_intv_clr();
      @(negedge clk); reload_val = 32'd0;
      do_ticks(5);
      chk("R8", "last fire before zero reload", 32'(intv_pend), 1);
      pulse_intv_clr();
      do_ticks(20);
      chk("R8", "zero reload leaves alarm idle", 32'(intv_pend), 0);
      pulse_load(0);
      do_ticks(20);
      chk("R8", "loading zero stays idle", 32'(intv_pend), 0);
   endtask

   task automatic t_two_flags();
      @(negedge clk); match_val = 20'd4; intv_ie = 1'b1;
      do_ticks(256 - 32'(sub_cnt));
      chk("R5", "sec at second match", sec_cnt, 4);
      chk("R5", "match flag at second match", 32'(match_pend), 1);
      pulse_load(2);
      do_ticks(2);
      chk("R7", "interval flag with period 2", 32'(intv_pend), 1);
      chk("R9", "irq with both flags", 32'(irq), 1);
      pulse_match_clr();
      chk("R10", "match cleared alone", 32'(match_pend), 0);
      chk("R10", "interval kept on match clear", 32'(intv_pend), 1);
      chk("R9", "irq from interval only", 32'(irq), 1);
      pulse_intv_clr();
      chk("R10", "interval cleared", 32'(intv_pend), 0);
      chk("R9", "irq low with no flags", 32'(irq), 0);
   endtask

   task automatic t_set_wins();
      pulse_load(1);
      @(negedge clk); tick = 1'b1; intv_clr = 1'b1;
      @(negedge clk); tick = 1'b0; intv_clr = 1'b0;
      chk("R10", "set beats clear on same edge", 32'(intv_pend), 1);
      pulse_intv_clr();
   endtask

   initial begin
      fork
         begin
            match_val = 20'd3;
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            run = 1'b1;
            t_reset();
            t_count();
            t_run_gate();
            t_carry();
            t_match();
            t_interval();
            t_reload_zero();
            t_two_flags();
            t_set_wins();
         end
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule